// File: doc/BRIEF.md
# PCI DMA Address Translator

This block converts a 32-bit address from the peripheral bus side of a bridge into a 48-bit address for the host link. The input space has three regions. The bottom gigabyte is local and is not translated. The second gigabyte is page-mapped through an internal table of 128 entries. Each entry covers a 4 KB page and carries a valid bit, attribute bits and a target ID. The upper two gigabytes are direct-mapped through one window register. That register supplies the high-order address bits in 2 GB steps and a target ID.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream, one cycle after acceptance. A request is accepted on a rising edge when both `req_valid` and `req_ready` are high. `req_ready` is high whenever the result register is empty or is being drained in the same cycle. A result whose `rsp_ready` is low is held unchanged, and no new request is taken until it drains.

A plain configuration port writes table entries as whole 64-bit words and writes the window register. The same port reads back either 32-bit half of any entry, or the window register. The read path is combinational.

Top module: `dma_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1. Every table entry reads back as zero and the window register reads back as zero.
- R2: A request with address bits 31:30 = 00 returns `rsp_local`=1, `rsp_err`=0, and zero on `rsp_addr`, `rsp_target` and `rsp_attr`.
- R3: A request with address bits 31:30 = 01 indexes the table with address bits 18:12, provided bits 29:19 are zero. If the entry's valid bit (bit 0) is set, the result is built from the entry as follows.
  - `rsp_addr` = {entry[47:12], request[11:0]}.
  - `rsp_target` = entry[11:8].
  - `rsp_attr` = entry[4:1], in the order {barrier, prefetch, precise, coherent}.
  - `rsp_local` = 0 and `rsp_err` = 0.
- R4: A mapped request that hits an entry whose bit 0 is clear returns `rsp_err`=1, with zero on `rsp_addr`, `rsp_target` and `rsp_attr`.
- R5: A mapped request with any of address bits 29:19 set selects an index beyond 127. It returns `rsp_err`=1 and zero address.
- R6: A request with address bit 31 set returns the following, with `rsp_err`=0 and `rsp_local`=0.
  - `rsp_addr` = {window offset (17 bits), request[30:0]}, which is offset × 2 GB plus the low 31 bits.
  - `rsp_target` = window register bits 23:20.
  - `rsp_attr` = 0.
- R7: The window register keeps its fields and reads back zero in every other bit. The fields are:
  - target ID in bits 23:20;
  - 64-bit read-modify flag in bit 18;
  - add-512 flag in bit 17;
  - offset in bits 16:0.
- R8: With `cfg_wr`=1 and `cfg_win`=0, the whole of `cfg_wdata` is written into entry `cfg_idx`. With `cfg_win`=0, `cfg_rdata` shows entry bits 63:32 when `cfg_hi`=1 and bits 31:0 when `cfg_hi`=0. With `cfg_win`=1, `cfg_rdata` shows the window register, and `cfg_wr` writes `cfg_wdata[31:0]` into it.
- R9: A request accepted on one edge shows its result on the next edge. A table write on the same edge as a request is not visible to that request, and is visible to a request on the following edge.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, every result output holds its value and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 32 | Bus-side address |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 48 | Translated host-link address |
| rsp_target | output | 4 | Target ID |
| rsp_attr | output | 4 | {barrier, prefetch, precise, coherent} |
| rsp_local | output | 1 | Address fell in the local region |
| rsp_err | output | 1 | Invalid entry or index beyond the table |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_win | input | 1 | 1 selects the window register, 0 selects the table |
| cfg_idx | input | 7 | Table entry index |
| cfg_hi | input | 1 | Read the upper half of the entry |
| cfg_wdata | input | 64 | Write data (window uses bits 31:0) |
| cfg_rdata | output | 32 | Read data |

## Verification
Faults in the table or the window register show up at the ports in two ways. They appear in the configuration read-back as soon as the read is issued. They also appear on the result one cycle after a request that touches the damaged field. Because of this, the bench reads back both halves of the entries it uses, in addition to sending lookups. A faulty region or range decode shows up as a wrong `rsp_local` or `rsp_err` one cycle after the request. A faulty stall path shows up as a result that changes, or a request that is lost, while `rsp_ready` is low.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  typedef enum logic [1:0] {
    RGN_LOCAL  = 2'd0,
    RGN_MAPPED = 2'd1,
    RGN_DIRECT = 2'd2
  } region_e;

  // entry field positions (fixed by the table format)
  localparam int ENT_W      = 64;
  localparam int ENT_VALID  = 0;
  localparam int ENT_ATTR_L = 1;
  localparam int ENT_ATTR_H = 4;
  localparam int ENT_TGT_L  = 8;
  localparam int ENT_TGT_H  = 11;
  localparam int ENT_PG_L   = 12;
  localparam int ENT_PG_H   = 47;

  // window register field positions
  localparam int WIN_TGT_L  = 20;
  localparam int WIN_TGT_H  = 23;
  localparam int WIN_RMF64  = 18;
  localparam int WIN_ADD512 = 17;
  localparam int WIN_OFF_H  = 16;
endpackage

// File: rtl/dxl_region_decode.sv
module dxl_region_decode
  import dxl_pkg::*;
#(
  parameter int BUS_AW = 32
) (
  input  logic [1:0] top_bits,
  output region_e    region
);
  always_comb begin
    if (top_bits[1])       region = RGN_DIRECT;
    else if (top_bits[0])  region = RGN_MAPPED;
    else                   region = RGN_LOCAL;
  end
endmodule

// File: rtl/dxl_entry_table.sv
module dxl_entry_table
  import dxl_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int PG_W    = ENT_PG_H - ENT_PG_L + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic [3:0]       lk_attr,
  output logic [3:0]       lk_tgt,
  output logic [PG_W-1:0]  lk_page,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_hi,
  output logic [31:0]      rd_half
);
  logic [ENT_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  logic [ENT_W-1:0] hit;
  assign hit      = mem[lk_idx];
  assign lk_valid = hit[ENT_VALID];
  assign lk_attr  = hit[ENT_ATTR_H:ENT_ATTR_L];
  assign lk_tgt   = hit[ENT_TGT_H:ENT_TGT_L];
  assign lk_page  = hit[ENT_PG_H:ENT_PG_L];

  logic [ENT_W-1:0] rd_word;
  assign rd_word = mem[rd_idx];
  assign rd_half = rd_hi ? rd_word[63:32] : rd_word[31:0];
endmodule

// File: rtl/dxl_window_reg.sv
module dxl_window_reg
  import dxl_pkg::*;
#(
  parameter int OFF_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [3:0]       win_tgt,
  output logic [OFF_W-1:0] win_off,
  output logic [31:0]      rd_word
);
  logic [3:0]       tgt_q;
  logic             rmf_q, add_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q <= '0;
      rmf_q <= 1'b0;
      add_q <= 1'b0;
      off_q <= '0;
    end else if (wr_en) begin
      tgt_q <= wr_data[WIN_TGT_H:WIN_TGT_L];
      rmf_q <= wr_data[WIN_RMF64];
      add_q <= wr_data[WIN_ADD512];
      off_q <= wr_data[OFF_W-1:0];
    end
  end

  assign win_tgt = tgt_q;
  assign win_off = off_q;

  always_comb begin
    rd_word                       = '0;
    rd_word[WIN_TGT_H:WIN_TGT_L]  = tgt_q;
    rd_word[WIN_RMF64]            = rmf_q;
    rd_word[WIN_ADD512]           = add_q;
    rd_word[OFF_W-1:0]            = off_q;
  end
endmodule

// File: rtl/dma_xlate.sv
module dma_xlate
  import dxl_pkg::*;
#(
  parameter int BUS_AW    = 32,
  parameter int HOST_AW   = 48,
  parameter int ENTRIES   = 128,
  parameter int PAGE_BITS = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [BUS_AW-1:0]  req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [HOST_AW-1:0] rsp_addr,
  output logic [3:0]         rsp_target,
  output logic [3:0]         rsp_attr,
  output logic               rsp_local,
  output logic               rsp_err,
  input  logic               cfg_wr,
  input  logic               cfg_win,
  input  logic [$clog2(ENTRIES)-1:0] cfg_idx,
  input  logic               cfg_hi,
  input  logic [63:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int PG_W   = HOST_AW - PAGE_BITS;
  localparam int OFF_W  = HOST_AW - (BUS_AW - 1);
  localparam int IDX_LO = PAGE_BITS;
  localparam int IDX_HI = PAGE_BITS + IDX_W - 1;
  localparam int OVR_LO = IDX_HI + 1;
  localparam int OVR_HI = BUS_AW - 3;

  region_e region;
  dxl_region_decode #(.BUS_AW(BUS_AW)) u_decode (
    .top_bits (req_addr[BUS_AW-1:BUS_AW-2]),
    .region   (region)
  );

  logic             lk_valid;
  logic [3:0]       lk_attr, lk_tgt;
  logic [PG_W-1:0]  lk_page;
  logic [31:0]      tbl_rd;

  dxl_entry_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .PG_W(PG_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr && !cfg_win),
    .wr_idx   (cfg_idx),
    .wr_data  (cfg_wdata),
    .lk_idx   (req_addr[IDX_HI:IDX_LO]),
    .lk_valid (lk_valid),
    .lk_attr  (lk_attr),
    .lk_tgt   (lk_tgt),
    .lk_page  (lk_page),
    .rd_idx   (cfg_idx),
    .rd_hi    (cfg_hi),
    .rd_half  (tbl_rd)
  );

  logic [3:0]       win_tgt;
  logic [OFF_W-1:0] win_off;
  logic [31:0]      win_rd;

  dxl_window_reg #(.OFF_W(OFF_W)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr && cfg_win),
    .wr_data (cfg_wdata[31:0]),
    .win_tgt (win_tgt),
    .win_off (win_off),
    .rd_word (win_rd)
  );

  assign cfg_rdata = cfg_win ? win_rd : tbl_rd;

  // index beyond the internal table
  logic idx_over;
  assign idx_over = |req_addr[OVR_HI:OVR_LO];

  logic [HOST_AW-1:0] nx_addr;
  logic [3:0]         nx_tgt, nx_attr;
  logic               nx_local, nx_err;

  always_comb begin
    nx_addr  = '0;
    nx_tgt   = '0;
    nx_attr  = '0;
    nx_local = 1'b0;
    nx_err   = 1'b0;
    unique case (region)
      RGN_LOCAL: nx_local = 1'b1;
      RGN_MAPPED: begin
        if (idx_over || !lk_valid) begin
          nx_err = 1'b1;
        end else begin
          nx_addr = {lk_page, req_addr[PAGE_BITS-1:0]};
          nx_tgt  = lk_tgt;
          nx_attr = lk_attr;
        end
      end
      RGN_DIRECT: begin
        nx_addr = {win_off, req_addr[BUS_AW-2:0]};
        nx_tgt  = win_tgt;
      end
      default: nx_err = 1'b1;
    endcase
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_addr   <= '0;
      rsp_target <= '0;
      rsp_attr   <= '0;
      rsp_local  <= 1'b0;
      rsp_err    <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr   <= nx_addr;
        rsp_target <= nx_tgt;
        rsp_attr   <= nx_attr;
        rsp_local  <= nx_local;
        rsp_err    <= nx_err;
      end
    end
  end
endmodule

// File: rtl/dma_xlate_sva.sv
module dma_xlate_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [47:0] rsp_addr,
  input logic [3:0]  rsp_target,
  input logic [3:0]  rsp_attr,
  input logic        rsp_local,
  input logic        rsp_err
);
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_target)
      && $stable(rsp_attr) && $stable(rsp_local) && $stable(rsp_err)); // R10

  AST_LOCAL_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_addr[31:30] == 2'b00 |=> rsp_local && !rsp_err && rsp_addr == '0); // R2

  AST_MAPPED_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_addr[31:30] == 2'b01
      |=> !rsp_local && (rsp_err || rsp_addr[11:0] == $past(req_addr[11:0]))); // R3

  AST_ERR_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_addr == '0 && rsp_attr == '0 && rsp_target == '0); // R4

  AST_DIRECT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_addr[31]
      |=> !rsp_err && !rsp_local && rsp_addr[30:0] == $past(req_addr[30:0]) && rsp_attr == '0); // R6

  AST_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_addr[31:30] == 2'b01 && req_addr[29:19] != '0 |=> rsp_err); // R5
endmodule

bind dma_xlate dma_xlate_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_addr   (rsp_addr),
  .rsp_target (rsp_target),
  .rsp_attr   (rsp_attr),
  .rsp_local  (rsp_local),
  .rsp_err    (rsp_err)
);

// File: tb/dma_xlate_tb.sv
`timescale 1ns/1ps
module dma_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [47:0] rsp_addr;
  logic [3:0]  rsp_target, rsp_attr;
  logic        rsp_local, rsp_err;
  logic        cfg_wr = 1'b0, cfg_win = 1'b0, cfg_hi = 1'b0;
  logic [6:0]  cfg_idx = '0;
  logic [63:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  always #10 clk = ~clk;

  dma_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_target(rsp_target), .rsp_attr(rsp_attr),
    .rsp_local(rsp_local), .rsp_err(rsp_err), .cfg_wr(cfg_wr), .cfg_win(cfg_win),
    .cfg_idx(cfg_idx), .cfg_hi(cfg_hi), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input bit win, input logic [6:0] idx, input logic [63:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_win = win; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input bit win, input logic [6:0] idx, input bit hi, output logic [31:0] d);
    @(negedge clk);
    cfg_win = win; cfg_idx = idx; cfg_hi = hi;
    #1 d = cfg_rdata;
  endtask

  // send one request, return the result one edge later
  task automatic send(input logic [31:0] a, output logic [57:0] res);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    res = {rsp_addr, rsp_target, rsp_attr, rsp_local, rsp_err};
    chk("R9 latency valid", {63'd0, rsp_valid}, 64'd1);
  endtask

  // {req no, addr, exp addr, tgt, attr, local, err}
  localparam logic [93:0] VEC [13] = '{
    {4'd2, 32'h0000_0000, 48'h0, 4'h0, 4'h0, 1'b1, 1'b0},          // R2 bottom
    {4'd2, 32'h3FFF_FFFF, 48'h0, 4'h0, 4'h0, 1'b1, 1'b0},          // R2 top of local
    {4'd3, 32'h4000_0ABC, 48'h1234_5678_9ABC, 4'hA, 4'h5, 1'b0, 1'b0}, // R3 entry 0
    {4'd3, 32'h4000_5FFF, 48'hFFFF_FFFF_FFFF, 4'h3, 4'hF, 1'b0, 1'b0}, // R3 entry 5
    {4'd3, 32'h4007_F000, 48'h0000_00AB_C000, 4'hF, 4'h9, 1'b0, 1'b0}, // R3 entry 127
    {4'd4, 32'h4000_6123, 48'h0, 4'h0, 4'h0, 1'b0, 1'b1},          // R4 bit0 clear
    {4'd4, 32'h4000_1000, 48'h0, 4'h0, 4'h0, 1'b0, 1'b1},          // R4 empty entry
    {4'd5, 32'h4008_0000, 48'h0, 4'h0, 4'h0, 1'b0, 1'b1},          // R5 index 128
    {4'd5, 32'h7FFF_FFFF, 48'h0, 4'h0, 4'h0, 1'b0, 1'b1},          // R5 top of mapped
    {4'd6, 32'h8000_0000, 48'h91A2_8000_0000, 4'h7, 4'h0, 1'b0, 1'b0}, // R6
    {4'd6, 32'hFFFF_FFFF, 48'h91A2_FFFF_FFFF, 4'h7, 4'h0, 1'b0, 1'b0}, // R6
    {4'd6, 32'h8000_1234, 48'h91A2_8000_1234, 4'h7, 4'h0, 1'b0, 1'b0}, // R6
    {4'd3, 32'h4000_0000, 48'h1234_5678_9000, 4'hA, 4'h5, 1'b0, 1'b0}  // R3 page base
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 actual=hang expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [57:0] res;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R1 req_ready", {63'd0, req_ready}, 64'd1);
    cfg_read(1'b0, 7'd0, 1'b0, rd);  chk("R1 entry0 low", {32'd0, rd}, 64'd0);
    cfg_read(1'b0, 7'd127, 1'b1, rd); chk("R1 entry127 high", {32'd0, rd}, 64'd0);
    cfg_read(1'b1, 7'd0, 1'b0, rd);  chk("R1 window", {32'd0, rd}, 64'd0);

    // configuration (R8, R7)
    cfg_write(1'b0, 7'd0,   64'hBEEF_1234_5678_9A0B);
    cfg_write(1'b0, 7'd5,   64'h0000_FFFF_FFFF_F31F);
    cfg_write(1'b0, 7'd127, 64'h0001_0000_00AB_CF13);
    cfg_write(1'b0, 7'd6,   64'h0000_0000_0000_0A1E);
    cfg_write(1'b1, 7'd0,   64'h0000_0000_FF7D_2345);

    cfg_read(1'b0, 7'd0, 1'b0, rd);  chk("R8 entry0 low",  {32'd0, rd}, 64'h5678_9A0B);
    cfg_read(1'b0, 7'd0, 1'b1, rd);  chk("R8 entry0 high", {32'd0, rd}, 64'hBEEF_1234);
    cfg_read(1'b0, 7'd127, 1'b1, rd); chk("R8 entry127 high", {32'd0, rd}, 64'h0001_0000);
    cfg_read(1'b1, 7'd0, 1'b0, rd);  chk("R7 window fields", {32'd0, rd}, 64'h0075_2345);

    // vector walk
    for (int i = 0; i < 13; i++) begin
      send(VEC[i][89:58], res);
      chk($sformatf("R%0d vector %0d", VEC[i][93:90], i), {6'd0, res}, {6'd0, VEC[i][57:0]});
    end

    // R9: write on the same edge as a request is not seen by it
    @(negedge clk);
    cfg_wr = 1'b1; cfg_win = 1'b0; cfg_idx = 7'd2; cfg_wdata = 64'h0000_0000_0000_1203;
    req_valid = 1'b1; req_addr = 32'h4000_2345;
    @(negedge clk);
    cfg_wr = 1'b0; req_valid = 1'b0;
    chk("R9 same-edge write unseen", {63'd0, rsp_err}, 64'd1);
    send(32'h4000_2345, res);
    chk("R9 write seen next edge", {6'd0, res},
        {6'd0, 48'h0000_0000_1345, 4'h2, 4'h1, 1'b0, 1'b0});

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h4000_0ABC;
    @(negedge clk);
    req_addr = 32'h0000_0010;
    chk("R10 ready low while stalled", {63'd0, req_ready}, 64'd0);
    chk("R10 first result", {16'd0, rsp_addr}, 64'h1234_5678_9ABC);
    @(negedge clk);
    chk("R10 result held", {15'd0, rsp_addr, rsp_local}, {15'd0, 48'h1234_5678_9ABC, 1'b0});
    chk("R10 valid held", {63'd0, rsp_valid}, 64'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 queued request taken", {62'd0, rsp_valid, rsp_local}, 64'd3);
    @(negedge clk);
    chk("R10 drained", {63'd0, rsp_valid}, 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule